// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block takes the decoded fields of a single-register load or store and produces the memory address for the access and the value to write back to the base register. It handles two instruction families. The first is the word/byte family, whose offset is either a 12-bit unsigned immediate or a register shifted by a 5-bit amount. The second is the halfword/signed-byte family, whose offset is either an 8-bit immediate split across two nibbles or an unshifted register.

A request strobe samples the inputs. One cycle later the unit presents its registered results:

- the access address;
- the base writeback value;
- a writeback enable;
- an illegal-encoding flag.

Three control bits set the addressing:

- Pre/post selects whether the offset is applied before the access or only to the writeback.
- Up/down selects whether the offset is added or subtracted.
- The writeback bit asks for the base update in pre-indexed mode.

The memory access itself and the register-file write belong to neighbouring blocks.

Top module: `ls_addr_gen`

## Requirements
- R1: Results appear on the outputs in the clock cycle after the cycle in which `req_i` was high, with `vld_o` high in that cycle only. In a cycle that does not follow a request, `vld_o`, `wb_en_o` and `illegal_o` are low.
- R2: With `pre_i`=1, `addr_o` equals the base plus or minus the offset.
- R3: With `pre_i`=0, `addr_o` equals the unmodified base and `wb_val_o` equals the base plus or minus the offset.
- R4: With `up_i`=1 the offset is added to the base; with `up_i`=0 it is subtracted.
- R5: `wb_en_o` is always high for post-indexed requests. For pre-indexed requests it is high only when `wb_i`=1. In pre-indexed mode `wb_val_o` equals `addr_o`.
- R6: Word/byte form (`hw_form_i`=0) with `imm_sel_i`=1 uses `field_i[11:0]` as a zero-extended unsigned offset.
- R7: Word/byte form with `imm_sel_i`=0 shifts `ofs_reg_i` by the amount in `field_i[11:7]`. The shift type is in `field_i[6:5]`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R8: An amount of 0 means a shift by 32 for the right shifts. Logical right then gives 0, and arithmetic right gives every bit equal to bit 31 of the register.
- R9: Rotate right with an amount of 0 gives `carry_i` in bit 31 and the register shifted right by one in bits 30..0.
- R10: Word/byte register form with `field_i[4]`=1 raises `illegal_o`, and `wb_en_o` stays low for it.
- R11: Halfword form (`hw_form_i`=1) with `imm_sel_i`=1 uses the 8-bit offset {`field_i[11:8]`, `field_i[3:0]`}. Bits 7..4 are ignored and never flag illegal.
- R12: Halfword form with `imm_sel_i`=0 uses `ofs_reg_i` unshifted, whatever `field_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, samples all other inputs |
| hw_form_i | input | 1 | 1 = halfword/signed-byte family, 0 = word/byte family |
| imm_sel_i | input | 1 | 1 = immediate offset, 0 = register offset |
| pre_i | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| up_i | input | 1 | 1 = add offset, 0 = subtract |
| wb_i | input | 1 | Writeback request for pre-indexed mode |
| field_i | input | 12 | Low instruction bits: immediate or shift specification |
| base_i | input | 32 | Base register value |
| ofs_reg_i | input | 32 | Offset register value |
| carry_i | input | 1 | Current carry flag |
| vld_o | output | 1 | Results valid |
| addr_o | output | 32 | Access address |
| wb_val_o | output | 32 | Base writeback value |
| wb_en_o | output | 1 | Base writeback enable |
| illegal_o | output | 1 | Illegal encoding detected |

## Verification
Offsets are exercised in every source: the word immediate, each of the four shift types at a non-zero amount, the zero-amount cases of the right shifts and of the rotate (with both carry values and with both sign values), the split halfword immediate, and the unshifted halfword register. The operand values are chosen so that a wrong shift direction, a missing sign fill, a wrong nibble join or a stray shift in the halfword path each gives a distinct address. Pre/post and up/down are paired with writeback on and off to separate address selection from writeback gating. An illegal word encoding and a halfword immediate with bit 4 set show that the illegal check is confined to one family.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned FIELD_W  = 12;
    localparam int unsigned HW_IMM_W = 8;

    // Shift specification bit positions inside the low instruction field
    localparam int unsigned SH_AMT_LSB  = 7;
    localparam int unsigned SH_KIND_LSB = 5;
    localparam int unsigned SH_ILL_BIT  = 4;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/lsag_shift.sv
module lsag_shift
    import ls_agu_pkg::*;
#(
    parameter int unsigned XLEN = DATA_W,
    localparam int unsigned AW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [AW-1:0]   amt_i,
    input  shift_kind_e     kind_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] res_o
);

    logic zero_amt;
    assign zero_amt = (amt_i == '0);

    always_comb begin
        unique case (kind_i)
            SH_LSL: res_o = val_i << amt_i;
            SH_LSR: res_o = zero_amt ? '0 : (val_i >> amt_i);
            SH_ASR: res_o = zero_amt ? {XLEN{val_i[XLEN-1]}}
                                     : $unsigned($signed(val_i) >>> amt_i);
            SH_ROR: res_o = zero_amt ? {carry_i, val_i[XLEN-1:1]}
                                     : ((val_i >> amt_i) | (val_i << (XLEN - amt_i)));
            default: res_o = val_i;
        endcase
    end

endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
    import ls_agu_pkg::*;
#(
    parameter int unsigned XLEN = DATA_W,
    localparam int unsigned AW  = $clog2(XLEN)
) (
    input  logic               hw_form_i,
    input  logic               imm_sel_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [XLEN-1:0]    ofs_reg_i,
    input  logic               carry_i,
    output logic [XLEN-1:0]    offset_o,
    output logic               illegal_o
);

    logic [XLEN-1:0]     shifted;
    logic [HW_IMM_W-1:0] hw_imm;
    shift_kind_e         kind;

    assign kind   = shift_kind_e'(field_i[SH_KIND_LSB +: 2]);
    assign hw_imm = {field_i[11:8], field_i[3:0]};

    lsag_shift #(.XLEN(XLEN)) u_shift (
        .val_i   (ofs_reg_i),
        .amt_i   (field_i[SH_AMT_LSB +: AW]),
        .kind_i  (kind),
        .carry_i (carry_i),
        .res_o   (shifted)
    );

    always_comb begin
        illegal_o = 1'b0;
        if (hw_form_i) begin
            offset_o = imm_sel_i ? {{(XLEN-HW_IMM_W){1'b0}}, hw_imm} : ofs_reg_i;
        end else if (imm_sel_i) begin
            offset_o = {{(XLEN-FIELD_W){1'b0}}, field_i};
        end else begin
            offset_o  = shifted;
            illegal_o = field_i[SH_ILL_BIT];
        end
    end

endmodule

// File: rtl/lsag_combine.sv
module lsag_combine #(
    parameter int unsigned XLEN = ls_agu_pkg::DATA_W
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic            pre_i,
    input  logic            up_i,
    input  logic            wb_i,
    input  logic            illegal_i,
    output logic [XLEN-1:0] addr_o,
    output logic [XLEN-1:0] wb_val_o,
    output logic            wb_en_o
);

    logic [XLEN-1:0] moved;

    assign moved    = up_i ? (base_i + offset_i) : (base_i - offset_i);
    assign addr_o   = pre_i ? moved : base_i;
    assign wb_val_o = moved;
    assign wb_en_o  = !illegal_i && (!pre_i || wb_i);

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_agu_pkg::*;
#(
    parameter int unsigned XLEN = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               hw_form_i,
    input  logic               imm_sel_i,
    input  logic               pre_i,
    input  logic               up_i,
    input  logic               wb_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [XLEN-1:0]    base_i,
    input  logic [XLEN-1:0]    ofs_reg_i,
    input  logic               carry_i,
    output logic               vld_o,
    output logic [XLEN-1:0]    addr_o,
    output logic [XLEN-1:0]    wb_val_o,
    output logic               wb_en_o,
    output logic               illegal_o
);

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_val;
        logic            wb_en;
        logic            illegal;
    } result_t;

    logic [XLEN-1:0] offset;
    logic            ill_c;
    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] wb_val_c;
    logic            wb_en_c;
    result_t         res_d, res_q;

    lsag_offset_sel #(.XLEN(XLEN)) u_ofs (
        .hw_form_i (hw_form_i),
        .imm_sel_i (imm_sel_i),
        .field_i   (field_i),
        .ofs_reg_i (ofs_reg_i),
        .carry_i   (carry_i),
        .offset_o  (offset),
        .illegal_o (ill_c)
    );

    lsag_combine #(.XLEN(XLEN)) u_comb (
        .base_i    (base_i),
        .offset_i  (offset),
        .pre_i     (pre_i),
        .up_i      (up_i),
        .wb_i      (wb_i),
        .illegal_i (ill_c),
        .addr_o    (addr_c),
        .wb_val_o  (wb_val_c),
        .wb_en_o   (wb_en_c)
    );

    always_comb begin
        res_d         = res_q;
        res_d.vld     = req_i;
        res_d.wb_en   = req_i && wb_en_c;
        res_d.illegal = req_i && ill_c;
        if (req_i) begin
            res_d.addr   = addr_c;
            res_d.wb_val = wb_val_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign vld_o     = res_q.vld;
    assign addr_o    = res_q.addr;
    assign wb_val_o  = res_q.wb_val;
    assign wb_en_o   = res_q.wb_en;
    assign illegal_o = res_q.illegal;

    // R10: an illegal encoding never writes the base back
    p_no_wb_on_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wb_en_o);

    // R1: flags stay low in a cycle that does not follow a request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (!wb_en_o && !illegal_o));

    // R1: valid follows the request by exactly one cycle
    p_vld_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o);

    // R3: post-indexed access uses the base sampled with the request
    p_post_addr_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !pre_i) |=> (addr_o == $past(base_i)));

    // R5: post-indexed legal requests always write back
    p_post_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !pre_i && !ill_c) |=> wb_en_o);

    // R5: pre-indexed without the writeback bit leaves the base alone
    p_pre_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && pre_i && !wb_i) |=> !wb_en_o);

    // R5: pre-indexed writeback value is the access address
    p_pre_wb_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && pre_i) |=> (wb_val_o == addr_o));

endmodule

// File: tb/tb_ls_addr_gen.sv
`timescale 1ns/1ps
module tb_ls_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        hw_form_i = 1'b0;
    logic        imm_sel_i = 1'b0;
    logic        pre_i = 1'b0;
    logic        up_i = 1'b0;
    logic        wb_i = 1'b0;
    logic [11:0] field_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] ofs_reg_i = '0;
    logic        carry_i = 1'b0;
    logic        vld_o;
    logic [31:0] addr_o;
    logic [31:0] wb_val_o;
    logic        wb_en_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ls_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .hw_form_i(hw_form_i),
        .imm_sel_i(imm_sel_i), .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i),
        .field_i(field_i), .base_i(base_i), .ofs_reg_i(ofs_reg_i),
        .carry_i(carry_i), .vld_o(vld_o), .addr_o(addr_o),
        .wb_val_o(wb_val_o), .wb_en_o(wb_en_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // Offset model built from 64-bit views of the register
    function automatic logic [31:0] model_ofs(input logic hw, input logic im,
            input logic [11:0] f, input logic [31:0] r, input logic c);
        int amt;
        logic [63:0] wide;
        amt = int'(f[11:7]);
        if (hw) return im ? {24'h0, f[11:8], f[3:0]} : r;
        if (im) return {20'h0, f};
        case (f[6:5])
            2'b00: return r << amt;
            2'b01: begin wide = {32'h0, r}; return wide[31:0] >> 0 == 0 ? 32'h0 : 32'(wide >> (amt == 0 ? 32 : amt)); end
            2'b10: begin wide = {{32{r[31]}}, r}; return 32'(wide >> (amt == 0 ? 32 : amt)); end
            default: begin
                if (amt == 0) return {c, r[31:1]};
                wide = {r, r};
                return 32'(wide >> amt);
            end
        endcase
    endfunction

    task automatic apply(input string tag, input logic hw, input logic im,
            input logic p, input logic u, input logic w, input logic [11:0] f,
            input logic [31:0] b, input logic [31:0] r, input logic c);
        logic [31:0] ofs, moved;
        logic        ill;
        ofs   = model_ofs(hw, im, f, r, c);
        moved = u ? b + ofs : b - ofs;
        ill   = !hw && !im && f[4];
        @(negedge clk);
        req_i = 1'b1; hw_form_i = hw; imm_sel_i = im; pre_i = p; up_i = u;
        wb_i = w; field_i = f; base_i = b; ofs_reg_i = r; carry_i = c;
        @(negedge clk);
        req_i = 1'b0;
        chk(tag, "vld", 32'(vld_o), 32'h1);
        chk(tag, "illegal", 32'(illegal_o), 32'(ill));
        chk(tag, "wb_en", 32'(wb_en_o), 32'(!ill && (!p || w)));
        if (!ill) begin
            chk(tag, "addr", addr_o, p ? moved : b);
            chk(tag, "wb_val", wb_val_o, moved);
        end
    endtask

    task automatic t_reset;
        chk("R1", "vld after reset", 32'(vld_o), 32'h0);
        chk("R1", "wb_en after reset", 32'(wb_en_o), 32'h0);
        chk("R1", "addr after reset", addr_o, 32'h0);
    endtask

    task automatic t_word_imm;   // R2 R4 R5 R6
        apply("R2_R6", 0, 1, 1, 1, 0, 12'h123, 32'h0000_1000, 32'h0, 0);
        chk("R2", "addr literal", addr_o, 32'h0000_1123);
        apply("R4_R5", 0, 1, 1, 0, 1, 12'hFFF, 32'h0000_1000, 32'h0, 0);
        chk("R4", "addr literal", addr_o, 32'h0000_0001);
    endtask

    task automatic t_post;       // R3 R5
        apply("R3", 0, 1, 0, 1, 0, 12'h040, 32'h2000_0000, 32'h0, 0);
        chk("R3", "wb literal", wb_val_o, 32'h2000_0040);
        apply("R3_R5", 0, 1, 0, 0, 1, 12'h010, 32'h0000_0100, 32'h0, 0);
    endtask

    task automatic t_shifts;     // R7
        apply("R7_lsl", 0, 0, 1, 1, 0, {5'd4, 2'b00, 5'b0}, 32'h10, 32'h12, 0);
        chk("R7", "lsl literal", addr_o, 32'h130);
        apply("R7_lsr", 0, 0, 1, 1, 0, {5'd8, 2'b01, 5'b0}, 32'h0, 32'h8000_0000, 0);
        chk("R7", "lsr literal", addr_o, 32'h0080_0000);
        apply("R7_asr", 0, 0, 1, 1, 0, {5'd4, 2'b10, 5'b0}, 32'h0, 32'h8000_0000, 0);
        chk("R7", "asr literal", addr_o, 32'hF800_0000);
        apply("R7_ror", 0, 0, 1, 1, 0, {5'd4, 2'b11, 5'b0}, 32'h0, 32'h1234_5678, 1);
        chk("R7", "ror literal", addr_o, 32'h8123_4567);
    endtask

    task automatic t_zero_amounts;  // R8 R9
        apply("R8_lsr0", 0, 0, 1, 1, 0, {5'd0, 2'b01, 5'b0}, 32'h500, 32'hFFFF_FFFF, 0);
        chk("R8", "lsr0 literal", addr_o, 32'h500);
        apply("R8_asr0n", 0, 0, 1, 0, 0, {5'd0, 2'b10, 5'b0}, 32'h500, 32'h8000_0000, 0);
        chk("R8", "asr0 neg literal", addr_o, 32'h501);
        apply("R8_asr0p", 0, 0, 1, 1, 0, {5'd0, 2'b10, 5'b0}, 32'h500, 32'h7FFF_FFFF, 0);
        chk("R8", "asr0 pos literal", addr_o, 32'h500);
        apply("R9_c1", 0, 0, 1, 1, 0, {5'd0, 2'b11, 5'b0}, 32'h0, 32'h3, 1);
        chk("R9", "rrx c1 literal", addr_o, 32'h8000_0001);
        apply("R9_c0", 0, 0, 1, 1, 0, {5'd0, 2'b11, 5'b0}, 32'h0, 32'h3, 0);
        chk("R9", "rrx c0 literal", addr_o, 32'h1);
    endtask

    task automatic t_illegal;    // R10
        apply("R10", 0, 0, 0, 1, 1, 12'h010, 32'h100, 32'h4, 0);
        chk("R10", "illegal literal", 32'(illegal_o), 32'h1);
    endtask

    task automatic t_halfword;   // R11 R12
        apply("R11", 1, 1, 1, 1, 0, 12'hA7C, 32'h1000, 32'h0, 0);
        chk("R11", "hw imm literal", addr_o, 32'h10AC);
        apply("R12", 1, 0, 1, 0, 1, 12'hFE0, 32'h1000, 32'h0000_0010, 1);
        chk("R12", "hw reg literal", addr_o, 32'h0FF0);
    endtask

    task automatic t_idle;       // R1
        @(negedge clk);
        chk("R1", "vld idle", 32'(vld_o), 32'h0);
        chk("R1", "wb_en idle", 32'(wb_en_o), 32'h0);
        chk("R1", "illegal idle", 32'(illegal_o), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_imm();
        t_post();
        t_shifts();
        t_zero_amounts();
        t_illegal();
        t_idle();
        t_halfword();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule